// File: doc/BRIEF.md
# Extended Memory Address Generator

This block builds the data-memory address for a small 8-bit accumulator processor. Each cycle it takes the immediate byte of the current instruction, a 3-bit mode field from the instruction decoder and the block's own X and Y index registers. From these it produces a page (high) byte and an offset (low) byte. It also decodes the destination of the instruction. It raises a strobe in the cycle in which X is stepped after the access.

The base machine can only place zero or Y in the page byte. Here the page multiplexer gains a third source. A parameter chooses what that source is, and so what mode code 001 means:
- the base behaviour, where the page is zero and the offset is X;
- a form where the immediate is the page and X is the offset;
- a form where X is the page and the immediate is the offset. This gives a 256-byte frame, while mode 000 still reaches the zero-page globals.

Both index registers are loaded from the memory data bus when the destination is X or Y. The memory holds 32 KB, so the page byte is masked to its significant bits. The address outputs are combinational. Only the index registers are clocked.

Top module: `xaddr_gen`

## Requirements
- R1: A synchronous reset clears X and Y to 0x00. The first [Y,X] access after reset therefore addresses page 0x00, offset 0x00.
- R2: Mode codes 000, 100, 101 and 110 address page 0x00 with the immediate byte as offset.
- R3: Mode code 010 addresses page Y with the immediate byte as offset.
- R4: Mode code 011 addresses page Y with X as offset.
- R5: With VARIANT=0, mode code 001 addresses page 0x00 with X as offset.
- R6: With VARIANT=1, mode code 001 addresses page = immediate, offset = X. With an immediate of 0x00 it gives exactly the VARIANT=0 address.
- R7: With VARIANT=2, mode code 001 addresses page = X, offset = immediate.
- R8: Mode code 111 addresses page Y, offset X using the X value from before the increment. During that cycle `x_post_inc` is 1, and X is one greater after the clock edge. In every other cycle `x_post_inc` is 0.
- R9: The X increment wraps from 0xFF to 0x00 and never changes Y or the page byte.
- R10: With ADDR_W=15, bit 7 of `addr_hi` is always 0, whatever the source of the page byte.
- R11: While `exec` is 1, `dest_sel` is one-hot: bit 0 is the accumulator (codes 000 to 011), bit 1 is X (100), bit 2 is Y (101) and bit 3 is the output register (110, 111).
- R12: An executed code 100 loads X from `wr_data` at the clock edge, and an executed code 101 loads Y from `wr_data` in the same way.
- R13: While `exec` is 0, `dest_sel` is 0x0, `x_post_inc` is 0, and X and Y keep their values whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | The current instruction executes this cycle |
| mode | input | 3 | Addressing-mode and destination code |
| imm_d | input | 8 | Immediate byte of the instruction |
| wr_data | input | 8 | Data-bus value loaded into X or Y |
| addr_hi | output | 8 | Page byte of the address (masked) |
| addr_lo | output | 8 | Offset byte of the address |
| x_post_inc | output | 1 | X steps after this access |
| dest_sel | output | 4 | One-hot destination: A, X, Y, OUT |

## Verification
The post-increment access and the update of X share one cycle. The address must still carry the old X while the register edge advances it. The bench provokes this by issuing code 111 and then an [Y,X] read on the next cycle, with X preloaded to 0x34 and then to 0xFF. The expected address is taken from a separate X model, so a late or early increment, or a carry into the page, shows up as a mismatch. A load that is not executed (`exec` 0) is placed just before such a read, so that any stray write would also show in the next address.

// File: rtl/xag_pkg.sv
package xag_pkg;

    localparam int BYTE_W = 8;
    localparam int DEST_W = 4;

    // variant selection for the third page-byte source
    localparam int VAR_BASE  = 0;
    localparam int VAR_DPAGE = 1;
    localparam int VAR_XPAGE = 2;

    // destination bit positions in the one-hot select
    localparam int DST_A   = 0;
    localparam int DST_X   = 1;
    localparam int DST_Y   = 2;
    localparam int DST_OUT = 3;

    typedef enum logic [1:0] {
        HI_ZERO = 2'd0,
        HI_Y    = 2'd1,
        HI_ALT  = 2'd2
    } hi_src_e;

    typedef enum logic {
        LO_IMM = 1'b0,
        LO_X   = 1'b1
    } lo_src_e;

    typedef struct packed {
        hi_src_e             hi_src;
        lo_src_e             lo_src;
        logic [DEST_W-1:0]   dest;
        logic                x_inc;
        logic                x_load;
        logic                y_load;
    } ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] x;
        logic [BYTE_W-1:0] y;
    } idx_t;

endpackage

// File: rtl/xag_mode_dec.sv
module xag_mode_dec
    import xag_pkg::*;
#(
    parameter int VARIANT = VAR_DPAGE,
    parameter int MODE_W  = 3
) (
    input  logic              exec,
    input  logic [MODE_W-1:0] mode,
    output ctl_t              ctl
);

    always_comb begin
        ctl        = '0;
        ctl.hi_src = HI_ZERO;
        ctl.lo_src = LO_IMM;
        case (mode)
            3'b000: begin
                ctl.dest[DST_A] = 1'b1;
            end
            3'b001: begin
                ctl.dest[DST_A] = 1'b1;
                if (VARIANT == VAR_DPAGE) begin
                    ctl.hi_src = HI_ALT;
                    ctl.lo_src = LO_X;
                end else if (VARIANT == VAR_XPAGE) begin
                    ctl.hi_src = HI_ALT;
                    ctl.lo_src = LO_IMM;
                end else begin
                    ctl.lo_src = LO_X;
                end
            end
            3'b010: begin
                ctl.hi_src      = HI_Y;
                ctl.dest[DST_A] = 1'b1;
            end
            3'b011: begin
                ctl.hi_src      = HI_Y;
                ctl.lo_src      = LO_X;
                ctl.dest[DST_A] = 1'b1;
            end
            3'b100: begin
                ctl.dest[DST_X] = 1'b1;
                ctl.x_load      = 1'b1;
            end
            3'b101: begin
                ctl.dest[DST_Y] = 1'b1;
                ctl.y_load      = 1'b1;
            end
            3'b110: begin
                ctl.dest[DST_OUT] = 1'b1;
            end
            default: begin
                ctl.hi_src        = HI_Y;
                ctl.lo_src        = LO_X;
                ctl.dest[DST_OUT] = 1'b1;
                ctl.x_inc         = 1'b1;
            end
        endcase
        // an idle slot still shows an address but has no side effect
        if (!exec) begin
            ctl.dest   = '0;
            ctl.x_inc  = 1'b0;
            ctl.x_load = 1'b0;
            ctl.y_load = 1'b0;
        end
    end

endmodule

// File: rtl/xag_addr_mux.sv
module xag_addr_mux
    import xag_pkg::*;
#(
    parameter int VARIANT = VAR_DPAGE,
    parameter int ADDR_W  = 15
) (
    input  hi_src_e           hi_src,
    input  lo_src_e           lo_src,
    input  logic [BYTE_W-1:0] imm_d,
    input  logic [BYTE_W-1:0] x_val,
    input  logic [BYTE_W-1:0] y_val,
    output logic [BYTE_W-1:0] addr_hi,
    output logic [BYTE_W-1:0] addr_lo
);

    localparam int HI_KEEP = ADDR_W - BYTE_W;
    localparam logic [BYTE_W-1:0] HI_MASK = BYTE_W'((1 << HI_KEEP) - 1);

    logic [BYTE_W-1:0] alt_src;
    logic [BYTE_W-1:0] hi_raw;

    // the spare multiplexer input is wired per variant
    generate
        if (VARIANT == VAR_XPAGE) begin : g_alt_x
            assign alt_src = x_val;
        end else begin : g_alt_imm
            assign alt_src = imm_d;
        end
    endgenerate

    always_comb begin
        case (hi_src)
            HI_Y:    hi_raw = y_val;
            HI_ALT:  hi_raw = alt_src;
            default: hi_raw = '0;
        endcase
        addr_hi = hi_raw & HI_MASK;
        addr_lo = (lo_src == LO_X) ? x_val : imm_d;
    end

endmodule

// File: rtl/xag_index_regs.sv
module xag_index_regs
    import xag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              x_load,
    input  logic              y_load,
    input  logic              x_inc,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] x_val,
    output logic [BYTE_W-1:0] y_val
);

    idx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (x_load) begin
            st_d.x = wr_data;
        end else if (x_inc) begin
            st_d.x = st_q.x + BYTE_W'(1);
        end
        if (y_load) begin
            st_d.y = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_val = st_q.x;
    assign y_val = st_q.y;

endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
    import xag_pkg::*;
#(
    parameter int VARIANT = VAR_DPAGE,
    parameter int ADDR_W  = 15,
    parameter int MODE_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  logic [MODE_W-1:0] mode,
    input  logic [7:0]        imm_d,
    input  logic [7:0]        wr_data,
    output logic [7:0]        addr_hi,
    output logic [7:0]        addr_lo,
    output logic              x_post_inc,
    output logic [3:0]        dest_sel
);

    ctl_t              ctl;
    logic [BYTE_W-1:0] x_q;
    logic [BYTE_W-1:0] y_q;

    xag_mode_dec #(
        .VARIANT (VARIANT),
        .MODE_W  (MODE_W)
    ) u_dec (
        .exec (exec),
        .mode (mode),
        .ctl  (ctl)
    );

    xag_index_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .x_load  (ctl.x_load),
        .y_load  (ctl.y_load),
        .x_inc   (ctl.x_inc),
        .wr_data (wr_data),
        .x_val   (x_q),
        .y_val   (y_q)
    );

    xag_addr_mux #(
        .VARIANT (VARIANT),
        .ADDR_W  (ADDR_W)
    ) u_mux (
        .hi_src  (ctl.hi_src),
        .lo_src  (ctl.lo_src),
        .imm_d   (imm_d),
        .x_val   (x_q),
        .y_val   (y_q),
        .addr_hi (addr_hi),
        .addr_lo (addr_lo)
    );

    assign x_post_inc = ctl.x_inc;
    assign dest_sel   = ctl.dest;

endmodule

// File: rtl/xaddr_gen_chk.sv
module xaddr_gen_chk #(
    parameter int ADDR_W = 15,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              exec,
    input logic [MODE_W-1:0] mode,
    input logic [7:0]        wr_data,
    input logic [7:0]        addr_hi,
    input logic              x_post_inc,
    input logic [3:0]        dest_sel,
    input logic [7:0]        x_q,
    input logic [7:0]        y_q
);

    localparam int HI_KEEP = ADDR_W - 8;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (x_q == 8'h00 && y_q == 8'h00));

    p_step_x_r8: assert property (@(posedge clk) disable iff (rst)
        x_post_inc |=> (x_q == 8'($past(x_q) + 8'd1)));

    p_no_carry_r9: assert property (@(posedge clk) disable iff (rst)
        x_post_inc |=> $stable(y_q));

    p_page_mask_r10: assert property (@(posedge clk) disable iff (rst)
        ((addr_hi >> HI_KEEP) == 8'h00));

    p_dest_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        exec |-> ($countones(dest_sel) == 1));

    p_load_x_r12: assert property (@(posedge clk) disable iff (rst)
        (exec && mode == 3'b100) |=> (x_q == $past(wr_data)));

    p_load_y_r12: assert property (@(posedge clk) disable iff (rst)
        (exec && mode == 3'b101) |=> (y_q == $past(wr_data)));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !exec |=> ($stable(x_q) && $stable(y_q)));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !exec |-> (dest_sel == 4'h0 && !x_post_inc));

endmodule

bind xaddr_gen xaddr_gen_chk #(
    .ADDR_W (ADDR_W),
    .MODE_W (MODE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .exec       (exec),
    .mode       (mode),
    .wr_data    (wr_data),
    .addr_hi    (addr_hi),
    .x_post_inc (x_post_inc),
    .dest_sel   (dest_sel),
    .x_q        (x_q),
    .y_q        (y_q)
);

// File: tb/xaddr_gen_bench.sv
`timescale 1ns/1ps
module xaddr_gen_bench;

    typedef struct {
        int         v;
        logic [7:0] hi;
        logic [7:0] lo;
        logic       inc;
        logic [3:0] dest;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [7:0] imm = 8'h00;
    logic [7:0] wr_data;

    logic [7:0] hi_w   [3];
    logic [7:0] lo_w   [3];
    logic       inc_w  [3];
    logic [3:0] dest_w [3];

    int    n_cmp = 0;
    int    n_bad = 0;
    logic  done  = 1'b0;
    item_t sb[$];
    event  mon_ev;
    logic [7:0] x_m = 8'h00;
    logic [7:0] y_m = 8'h00;

    always #2.5 clk = ~clk;

    // behavioural RAM: zero page returns the offset itself
    function automatic logic [7:0] ram_rd(input logic [7:0] h, input logic [7:0] l);
        return l ^ {h[6:0], 1'b0};
    endfunction

    assign wr_data = ram_rd(hi_w[0], lo_w[0]);

    // v=0: base variant, v=1: [D,X] variant (main instance), v=2: [X,D] variant
    xaddr_gen #(.VARIANT(0)) u_base (
        .clk(clk), .rst(rst), .exec(exec), .mode(mode), .imm_d(imm), .wr_data(wr_data),
        .addr_hi(hi_w[0]), .addr_lo(lo_w[0]), .x_post_inc(inc_w[0]), .dest_sel(dest_w[0]));
    xaddr_gen #(.VARIANT(1)) u_xaddr_gen (
        .clk(clk), .rst(rst), .exec(exec), .mode(mode), .imm_d(imm), .wr_data(wr_data),
        .addr_hi(hi_w[1]), .addr_lo(lo_w[1]), .x_post_inc(inc_w[1]), .dest_sel(dest_w[1]));
    xaddr_gen #(.VARIANT(2)) u_frame (
        .clk(clk), .rst(rst), .exec(exec), .mode(mode), .imm_d(imm), .wr_data(wr_data),
        .addr_hi(hi_w[2]), .addr_lo(lo_w[2]), .x_post_inc(inc_w[2]), .dest_sel(dest_w[2]));

    function automatic item_t predict(input int v, input logic e, input logic [2:0] m,
                                      input logic [7:0] d, input string req);
        item_t it;
        it.v = v;
        it.req = req;
        case (m)
            3'b001: begin
                if (v == 0)      begin it.hi = 8'h00; it.lo = x_m; end
                else if (v == 1) begin it.hi = d;     it.lo = x_m; end
                else             begin it.hi = x_m;   it.lo = d;   end
            end
            3'b010:          begin it.hi = y_m; it.lo = d;   end
            3'b011, 3'b111:  begin it.hi = y_m; it.lo = x_m; end
            default:         begin it.hi = 8'h00; it.lo = d; end
        endcase
        it.hi = it.hi & 8'h7F;
        if (!e)               it.dest = 4'h0;
        else if (m <= 3'b011) it.dest = 4'b0001;
        else if (m == 3'b100) it.dest = 4'b0010;
        else if (m == 3'b101) it.dest = 4'b0100;
        else                  it.dest = 4'b1000;
        it.inc = e && (m == 3'b111);
        return it;
    endfunction

    task automatic issue(input logic e, input logic [2:0] m, input logic [7:0] d, input string req);
        @(negedge clk);
        exec = e;
        mode = m;
        imm  = d;
        for (int v = 0; v < 3; v++) sb.push_back(predict(v, e, m, d, req));
        #1 -> mon_ev;
        if (e) begin
            if (m == 3'b100) x_m = d;
            if (m == 3'b101) y_m = d;
            if (m == 3'b111) x_m = x_m + 8'd1;
        end
    endtask

    // monitor: pops scoreboard items and compares against the instance outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_cmp++;
                if (hi_w[it.v] !== it.hi || lo_w[it.v] !== it.lo ||
                    inc_w[it.v] !== it.inc || dest_w[it.v] !== it.dest) begin
                    n_bad++;
                    $display("FAIL %s v=%0d: got hi=%h lo=%h inc=%b dest=%b, expected hi=%h lo=%h inc=%b dest=%b",
                             it.req, it.v, hi_w[it.v], lo_w[it.v], inc_w[it.v], dest_w[it.v],
                             it.hi, it.lo, it.inc, it.dest);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        issue(1'b0, 3'b011, 8'h00, "R13 idle after reset");
        issue(1'b1, 3'b011, 8'h5A, "R1 reset clears X,Y");
        issue(1'b1, 3'b100, 8'h34, "R12 R2 R11 load X");
        issue(1'b1, 3'b101, 8'h12, "R12 R2 R11 load Y");
        issue(1'b1, 3'b000, 8'h56, "R2 R11 zero page to A");
        issue(1'b1, 3'b110, 8'h9A, "R2 R11 zero page to OUT");
        issue(1'b1, 3'b010, 8'h21, "R3 [Y,D]");
        issue(1'b1, 3'b011, 8'h77, "R4 [Y,X]");
        issue(1'b1, 3'b001, 8'h07, "R5 R6 R7 mode 001");
        issue(1'b1, 3'b001, 8'h00, "R6 zero page equivalence");
        issue(1'b1, 3'b111, 8'hEE, "R8 post-increment access");
        issue(1'b1, 3'b011, 8'h00, "R8 X stepped");
        issue(1'b0, 3'b100, 8'h99, "R13 unexecuted load");
        issue(1'b1, 3'b011, 8'h00, "R13 X unchanged");
        issue(1'b0, 3'b111, 8'h00, "R13 unexecuted increment");
        issue(1'b1, 3'b011, 8'h00, "R13 X not stepped");
        issue(1'b1, 3'b100, 8'hFF, "R12 load X=FF");
        issue(1'b1, 3'b111, 8'h00, "R9 increment at FF");
        issue(1'b1, 3'b011, 8'h00, "R9 wrap without carry");
        issue(1'b1, 3'b101, 8'hFF, "R12 load Y=FF");
        issue(1'b1, 3'b010, 8'h01, "R10 Y page masked");
        issue(1'b1, 3'b001, 8'hC3, "R10 R6 immediate page masked");
        issue(1'b1, 3'b100, 8'hAB, "R12 load X=AB");
        issue(1'b1, 3'b001, 8'h10, "R7 R10 X page masked");
        issue(1'b1, 3'b111, 8'h00, "R8 strobe with X page");
        issue(1'b1, 3'b001, 8'h20, "R7 frame after step");
        @(negedge clk);
        exec = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule